// File: doc/BRIEF.md
# Boot Memory Remap Address Decoder

This block turns a 32-bit processor address into a choice of on-chip memory and an offset into it. Two physical memories are decoded: a 64 KB Flash region starting at 0x0008_0000 and an 8 KB SRAM region starting at 0x0001_0000. A 64 KB window at address zero, which holds the exception vectors (0x0000_0000 to 0x0000_0020), aliases one of the two memories. A single control bit decides which one.

The control bit lives in a one-bit register that software can read and write. Writing 1 makes the low window show the SRAM, so exception handlers can run from the faster memory. Writing 0 brings the Flash back. Every reset clears the bit, so the processor always boots from Flash. The decode itself is purely combinational from the address and the stored bit. Its outputs are a one-hot choice among Flash, SRAM and nothing, plus the local offset the selected memory should use.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset the remap bit is 0, a register read returns 0x0000_0000, and the low window aliases Flash.
- R2: An address in 0x0008_0000..0x0008_FFFF raises `sel_flash`, with `mem_offset` = address − 0x0008_0000.
- R3: An address in 0x0001_0000..0x0001_1FFF raises `sel_sram`, with `mem_offset` = address − 0x0001_0000.
- R4: With the remap bit at 0, an address in 0x0000_0000..0x0000_FFFF raises `sel_flash`, with `mem_offset` equal to the address.
- R5: With the remap bit at 1, an address in 0x0000_0000..0x0000_FFFF raises `sel_sram`, with `mem_offset` = address modulo 0x2000.
- R6: Any other address raises `sel_none`, keeps `sel_flash` and `sel_sram` low, and drives `mem_offset` to 0.
- R7: Exactly one of `sel_flash`, `sel_sram` and `sel_none` is high at all times outside reset.
- R8: A write (`cfg_sel` and `cfg_we` high at a rising edge) stores `cfg_wdata[0]`. The decode changes only after that edge. A cycle with `cfg_we` high but `cfg_sel` low leaves the bit unchanged.
- R9: While `cfg_sel` is high, `cfg_rdata` returns the remap bit in position 0 and zeros in bits 31..1. While `cfg_sel` is low, `cfg_rdata` is 0. Bits 31..1 of `cfg_wdata` are not stored.
- R10: Writing 0 after a 1, or applying a reset, returns the low window to the Flash alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Remap register is addressed this cycle |
| cfg_we | input | 1 | Write strobe for the remap register |
| cfg_wdata | input | 32 | Write data; only bit 0 is kept |
| cfg_rdata | output | 32 | Register read data |
| bus_addr | input | 32 | Processor address to decode |
| sel_flash | output | 1 | Address maps to Flash |
| sel_sram | output | 1 | Address maps to SRAM |
| sel_none | output | 1 | Address maps to no memory |
| mem_offset | output | 16 | Local offset inside the selected memory |

## Verification
The decode is tried at the first and last byte of each physical region and of the low window, and at the addresses just outside each of them. This shows whether the range compares are off by one. Low-window addresses are decoded under both values of the bit, including 0x2004, which must wrap to offset 4 only when SRAM is aliased. Register traffic covers a write with the strobe but without the select, which must change nothing, and a write with all ones, which must read back as 1. It also checks the cycle between a write's setup and its clock edge, and a reset taken while SRAM is aliased.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] FLASH_BASE_D  = 32'h0008_0000;
  localparam int unsigned       FLASH_LOG2_D  = 16;
  localparam logic [ADDR_W-1:0] SRAM_BASE_D   = 32'h0001_0000;
  localparam int unsigned       SRAM_LOG2_D   = 13;
  localparam logic [ADDR_W-1:0] MIRROR_BASE_D = 32'h0000_0000;
  localparam int unsigned       MIRROR_LOG2_D = 16;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_FLASH = 2'd1,
    RGN_SRAM  = 2'd2
  } region_e;

  // true when addr falls into the naturally aligned window [base, base + 2**lg)
  function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input int unsigned lg);
    return (addr >> lg) == (base >> lg);
  endfunction

  // low lg bits of addr, everything above cleared
  function automatic logic [ADDR_W-1:0] low_bits(input logic [ADDR_W-1:0] addr,
                                                 input int unsigned lg);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << lg) - ADDR_W'(1);
    return addr & mask;
  endfunction

endpackage

// File: rtl/remap_ctrl_reg.sv
module remap_ctrl_reg
  import bootmap_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          remap_o
);

  logic remap_q;
  logic wr_fire;
  logic unused_wdata_hi;

  assign wr_fire         = sel & we;
  assign unused_wdata_hi = ^wdata[DW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remap_q <= 1'b0;
    end else if (wr_fire) begin
      remap_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      rdata[0] = remap_q;
    end
  end

  assign remap_o = remap_q;

endmodule

// File: rtl/region_match.sv
module region_match
  import bootmap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE      = '0,
  parameter int unsigned       SIZE_LOG2 = 16,
  parameter int unsigned       OFF_W     = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);

  logic [ADDR_W-1:0] off_full;

  assign hit      = in_window(addr, BASE, SIZE_LOG2);
  assign off_full = low_bits(addr, SIZE_LOG2);
  assign off      = off_full[OFF_W-1:0];

endmodule

// File: rtl/region_decode.sv
module region_decode
  import bootmap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FLASH_BASE  = FLASH_BASE_D,
  parameter int unsigned       FLASH_LOG2  = FLASH_LOG2_D,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = SRAM_BASE_D,
  parameter int unsigned       SRAM_LOG2   = SRAM_LOG2_D,
  parameter logic [ADDR_W-1:0] MIRROR_BASE = MIRROR_BASE_D,
  parameter int unsigned       MIRROR_LOG2 = MIRROR_LOG2_D,
  parameter int unsigned       OFF_W       = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap,
  output region_e           region,
  output logic              mirror_hit,
  output logic [OFF_W-1:0]  off
);

  localparam int unsigned NRGN = 3;
  localparam int unsigned IDX_FLASH  = 0;
  localparam int unsigned IDX_SRAM   = 1;
  localparam int unsigned IDX_MIRROR = 2;
  localparam logic [ADDR_W-1:0] BASES [NRGN] = '{FLASH_BASE, SRAM_BASE, MIRROR_BASE};
  localparam int unsigned       LOGS  [NRGN] = '{FLASH_LOG2, SRAM_LOG2, MIRROR_LOG2};
  localparam logic [OFF_W-1:0] FLASH_MASK = OFF_W'((ADDR_W'(1) << FLASH_LOG2) - 1);
  localparam logic [OFF_W-1:0] SRAM_MASK  = OFF_W'((ADDR_W'(1) << SRAM_LOG2) - 1);

  logic [NRGN-1:0] hits;
  logic [OFF_W-1:0] offs [NRGN];

  for (genvar g = 0; g < NRGN; g++) begin : g_match
    region_match #(
      .BASE     (BASES[g]),
      .SIZE_LOG2(LOGS[g]),
      .OFF_W    (OFF_W)
    ) u_match (
      .addr(addr),
      .hit (hits[g]),
      .off (offs[g])
    );
  end

  assign mirror_hit = hits[IDX_MIRROR];

  always_comb begin
    region = RGN_NONE;
    off    = '0;
    if (hits[IDX_FLASH]) begin
      region = RGN_FLASH;
      off    = offs[IDX_FLASH];
    end else if (hits[IDX_SRAM]) begin
      region = RGN_SRAM;
      off    = offs[IDX_SRAM];
    end else if (hits[IDX_MIRROR]) begin
      if (remap) begin
        region = RGN_SRAM;
        off    = offs[IDX_MIRROR] & SRAM_MASK;
      end else begin
        region = RGN_FLASH;
        off    = offs[IDX_MIRROR] & FLASH_MASK;
      end
    end
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import bootmap_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FLASH_BASE  = FLASH_BASE_D,
  parameter int unsigned       FLASH_LOG2  = FLASH_LOG2_D,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = SRAM_BASE_D,
  parameter int unsigned       SRAM_LOG2   = SRAM_LOG2_D,
  parameter logic [ADDR_W-1:0] MIRROR_BASE = MIRROR_BASE_D,
  parameter int unsigned       MIRROR_LOG2 = MIRROR_LOG2_D,
  localparam int unsigned      OFF_W = (FLASH_LOG2 > SRAM_LOG2) ? FLASH_LOG2 : SRAM_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              sel_flash,
  output logic              sel_sram,
  output logic              sel_none,
  output logic [OFF_W-1:0]  mem_offset
);

  logic    remap_bit;
  logic    mirror_hit;
  region_e region;

  remap_ctrl_reg #(.DW(DATA_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (cfg_sel),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .remap_o(remap_bit)
  );

  region_decode #(
    .FLASH_BASE (FLASH_BASE),
    .FLASH_LOG2 (FLASH_LOG2),
    .SRAM_BASE  (SRAM_BASE),
    .SRAM_LOG2  (SRAM_LOG2),
    .MIRROR_BASE(MIRROR_BASE),
    .MIRROR_LOG2(MIRROR_LOG2),
    .OFF_W      (OFF_W)
  ) u_dec (
    .addr      (bus_addr),
    .remap     (remap_bit),
    .region    (region),
    .mirror_hit(mirror_hit),
    .off       (mem_offset)
  );

  assign sel_flash = (region == RGN_FLASH);
  assign sel_sram  = (region == RGN_SRAM);
  assign sel_none  = (region == RGN_NONE);

endmodule

// File: rtl/boot_remap_checker.sv
module boot_remap_checker
  import bootmap_pkg::*;
#(
  parameter int unsigned OFF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_sel,
  input logic              cfg_we,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              sel_flash,
  input logic              sel_sram,
  input logic              sel_none,
  input logic [OFF_W-1:0]  mem_offset,
  input logic              remap_bit,
  input logic              mirror_hit
);

  a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_flash, sel_sram, sel_none}) == 1);

  a_r8_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && cfg_we) |=> (remap_bit == $past(cfg_wdata[0])));

  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_sel && cfg_we) |=> $stable(remap_bit));

  a_r6_none_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    sel_none |-> (mem_offset == '0));

  a_r9_upper_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DATA_W-1:1] == '0);

  a_r5_mirror_sram: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_hit && remap_bit) |-> sel_sram);

  a_r4_mirror_flash: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_hit && !remap_bit) |-> sel_flash);

endmodule

bind boot_remap_decoder boot_remap_checker #(.OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_sel   (cfg_sel),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .sel_flash (sel_flash),
  .sel_sram  (sel_sram),
  .sel_none  (sel_none),
  .mem_offset(mem_offset),
  .remap_bit (remap_bit),
  .mirror_hit(mirror_hit)
);

// File: tb/boot_remap_decoder_test.sv
module boot_remap_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] bus_addr = '0;
  logic        sel_flash, sel_sram, sel_none;
  logic [15:0] mem_offset;

  int checks = 0;
  int errors = 0;
  bit model_remap = 1'b0;

  logic [18:0] exp_q [$];
  string       tag_q [$];
  event        do_chk;

  always #4 clk = ~clk;  // 125 MHz

  boot_remap_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
    .sel_flash(sel_flash), .sel_sram(sel_sram), .sel_none(sel_none),
    .mem_offset(mem_offset)
  );

  // expected {flash, sram, none, offset} restated from the requirements
  function automatic logic [18:0] expect_of(input logic [31:0] a, input bit rm);
    if (a >= 32'h0008_0000 && a <= 32'h0008_FFFF) return {3'b100, 16'(a - 32'h0008_0000)};
    if (a >= 32'h0001_0000 && a <= 32'h0001_1FFF) return {3'b010, 16'(a - 32'h0001_0000)};
    if (a <= 32'h0000_FFFF) return rm ? {3'b010, 16'(a % 32'h2000)} : {3'b100, 16'(a)};
    return {3'b001, 16'h0000};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard and compares against the ports
  initial forever begin
    logic [18:0] e, a;
    string t;
    @(do_chk);
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    a = {sel_flash, sel_sram, sel_none, mem_offset};
    check(a == e, t, 32'(a), 32'(e));
    check($countones(a[18:16]) == 1, "R7", 32'(a[18:16]), 32'h1);
  end

  // driver: presents an address and queues its expected decode
  task automatic drive_addr(input logic [31:0] a, input string req);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(expect_of(a, model_remap));
    tag_q.push_back(req);
    #2;
    ->do_chk;
    #1;
  endtask

  task automatic reg_write(input logic [31:0] d, input bit sel);
    @(negedge clk);
    cfg_sel = sel; cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_sel = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    if (sel) model_remap = d[0];
  endtask

  task automatic reg_read(input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_sel = 1'b1;
    #1;
    check(cfg_rdata == exp, req, cfg_rdata, exp);
    cfg_sel = 1'b0;
    #1;
    check(cfg_rdata == 32'h0, req, cfg_rdata, 32'h0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    reg_read(32'h0, "R1");
    drive_addr(32'h0000_0000, "R1");
    // R2 flash region edges
    drive_addr(32'h0008_0000, "R2");
    drive_addr(32'h0008_1234, "R2");
    drive_addr(32'h0008_FFFF, "R2");
    // R3 sram region edges
    drive_addr(32'h0001_0000, "R3");
    drive_addr(32'h0001_1FFF, "R3");
    // R4 flash alias
    drive_addr(32'h0000_0020, "R4");
    drive_addr(32'h0000_2004, "R4");
    drive_addr(32'h0000_FFFF, "R4");
    // R6 unmapped addresses
    drive_addr(32'h0001_2000, "R6");
    drive_addr(32'h0007_FFFF, "R6");
    drive_addr(32'h0009_0000, "R6");
    drive_addr(32'hFFFF_FFFF, "R6");
    // R8 timing: decode unchanged before the write edge
    @(negedge clk);
    bus_addr = 32'h0000_0010;
    cfg_sel = 1'b1; cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    #1;
    check(sel_flash == 1'b1, "R8", 32'(sel_flash), 32'h1);
    @(posedge clk);
    #1;
    cfg_sel = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    model_remap = 1'b1;
    check(sel_sram == 1'b1 && mem_offset == 16'h0010, "R8", {15'h0, sel_sram, mem_offset}, 32'h1_0010);
    // R9 readback of all-ones write
    reg_read(32'h1, "R9");
    // R5 sram alias with wrap
    drive_addr(32'h0000_0000, "R5");
    drive_addr(32'h0000_1FFF, "R5");
    drive_addr(32'h0000_2004, "R5");
    drive_addr(32'h0000_FFFF, "R5");
    drive_addr(32'h0008_0004, "R2");
    drive_addr(32'h0001_0008, "R3");
    // R8 write without select ignored
    reg_write(32'h0, 1'b0);
    drive_addr(32'h0000_0100, "R8");
    reg_read(32'h1, "R8");
    // R10 software clear
    reg_write(32'hFFFF_FFFE, 1'b1);
    drive_addr(32'h0000_0100, "R10");
    reg_read(32'h0, "R10");
    // R10 reset while aliasing sram
    reg_write(32'h1, 1'b1);
    drive_addr(32'h0000_0004, "R5");
    @(negedge clk);
    rst_n = 1'b0;
    model_remap = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive_addr(32'h0000_0004, "R10");
    reg_read(32'h0, "R10");
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule